// File: doc/BRIEF.md
# Rate-Coded Spike Train Encoder

The encoder turns a vector of non-negative channel intensities into binary spike trains that span a programmed window of time slots. When a frame is started, it latches the intensities together with two configuration values: the total spike budget and the window length. It then works out each channel's spike count from that channel's share of the summed intensity. A sequential divider does this per channel during a setup phase, before any slot is issued.

Once setup is done, the encoder issues one slot per clock cycle. In each slot every channel emits either zero or one spike. The spike positions come from a per-channel pseudo-random sequence and a selection-sampling rule. The rule fires when the scaled random value is below the channel's remaining count, measured against the slots still left. As a result, each channel emits exactly its computed count, spread unpredictably across the window. A frame-done flag marks the final slot. The spike outputs feed the downstream network logic directly.

Top module: `spike_rate_encoder`

## Requirements
- R1: After reset, `spike_o`, `slot_valid_o`, `frame_done_o` and `busy_o` are all 0.
- R2: In a frame, channel c emits `floor((2*Ns*v_c + S) / (2*S))` spikes. Here Ns is the latched budget, v_c is the channel's intensity and S is the sum of all intensities. This is round-half-up of `Ns*v_c/S`. Channel c occupies bits `[c*VAL_W +: VAL_W]` of `intensity_i` and bit c of `spike_o`.
- R3: A channel's spike count is clamped to Nt, the latched window length. A count of at least Nt therefore fires in every slot.
- R4: When every intensity is zero, the frame contains no spikes.
- R5: A frame drives `slot_valid_o` high for exactly Nt cycles, with Nt from 1 to 2^SLOT_W-1.
- R6: `frame_done_o` is a one-cycle pulse in the same cycle as the last slot. In the following cycle, `slot_valid_o` is low.
- R7: A `spike_o` bit can be 1 only while `slot_valid_o` is 1, and then it is a single bit per channel per slot.
- R8: While `busy_o` is high, `start_i` and any change to the intensities or configuration have no effect on the current frame.
- R9: Frames can be run one after another. Each frame uses the configuration latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a frame when the encoder is idle |
| intensity_i | input | NUM_CH*VAL_W | Packed channel intensities |
| total_spikes_i | input | CNT_W | Spike budget Ns for the frame |
| slot_count_i | input | SLOT_W | Window length Nt in slots |
| spike_o | output | NUM_CH | One spike bit per channel for the current slot |
| slot_valid_o | output | 1 | Marks a cycle that carries a slot |
| frame_done_o | output | 1 | Pulses with the last slot of a frame |
| busy_o | output | 1 | High from the start of a frame until its last slot |

## Verification
The bound checker watches three properties on every cycle: spikes appear only inside slots, the done pulse lines up with a slot and is followed by a quiet cycle, and the number of slots in a frame never exceeds the latched window length and reaches it exactly at the done pulse. The checker cannot see the per-channel spike totals, since it holds no model of the rounding, the clamp or the zero-sum case. The bench's scenarios establish these totals by comparing each frame's counts against the closed-form expression. The scenarios also cover the rejection of a restart during a frame and the back-to-back frames with different settings.

// File: rtl/enc_pkg.sv
package enc_pkg;
    typedef enum logic [1:0] {
        ENC_IDLE   = 2'd0,
        ENC_LAUNCH = 2'd1,
        ENC_WAIT   = 2'd2,
        ENC_RUN    = 2'd3
    } enc_state_e;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_TAPS = 16'hB400;
endpackage

// File: rtl/enc_divider.sv
module enc_divider #(
    parameter int DIVD_W = 22,
    parameter int DVS_W  = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic [DIVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0]  divisor_i,
    output logic [DIVD_W-1:0] quot_o,
    output logic              done_o
);
    localparam int STEP_W = $clog2(DIVD_W + 1);

    typedef struct packed {
        logic [DVS_W-1:0]  rem;
        logic [DIVD_W-1:0] quo;
        logic [STEP_W-1:0] steps;
        logic              done;
    } div_regs_t;

    div_regs_t r_d, r_q;
    logic [DVS_W:0] trial;
    logic [DVS_W:0] diff;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        trial    = {r_q.rem, r_q.quo[DIVD_W-1]};
        diff     = trial - {1'b0, divisor_i};
        if (go_i) begin
            r_d.rem   = '0;
            r_d.quo   = dividend_i;
            r_d.steps = STEP_W'(DIVD_W);
        end else if (r_q.steps != '0) begin
            if (trial >= {1'b0, divisor_i}) begin
                r_d.rem = diff[DVS_W-1:0];
                r_d.quo = {r_q.quo[DIVD_W-2:0], 1'b1};
            end else begin
                r_d.rem = trial[DVS_W-1:0];
                r_d.quo = {r_q.quo[DIVD_W-2:0], 1'b0};
            end
            r_d.steps = r_q.steps - 1'b1;
            r_d.done  = (r_q.steps == STEP_W'(1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign quot_o = r_q.quo;
    assign done_o = r_q.done;
endmodule

// File: rtl/enc_lfsr.sv
module enc_lfsr #(
    parameter logic [enc_pkg::RND_W-1:0] SEED = 16'h1D87
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      adv_i,
    output logic [enc_pkg::RND_W-1:0] rnd_o
);
    import enc_pkg::*;

    logic [RND_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q;
        if (adv_i) begin
            lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? RND_TAPS : '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= SEED;
        else         lfsr_q <= lfsr_d;
    end

    assign rnd_o = lfsr_q;
endmodule

// File: rtl/enc_fire_gate.sv
module enc_fire_gate #(
    parameter int SLOT_W = 8,
    parameter int RND_W  = 16
) (
    input  logic [RND_W-1:0]  rnd_i,
    input  logic [SLOT_W-1:0] left_i,
    input  logic [SLOT_W-1:0] remain_i,
    output logic              fire_o
);
    logic [RND_W+SLOT_W-1:0] prod;
    logic [SLOT_W-1:0]       scaled;

    always_comb begin
        prod   = (RND_W+SLOT_W)'(rnd_i) * (RND_W+SLOT_W)'(left_i);
        scaled = prod[RND_W+SLOT_W-1:RND_W];
        fire_o = (scaled < remain_i);
    end
endmodule

// File: rtl/spike_rate_encoder.sv
module spike_rate_encoder #(
    parameter int NUM_CH = 4,
    parameter int VAL_W  = 8,
    parameter int CNT_W  = 12,
    parameter int SLOT_W = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [NUM_CH*VAL_W-1:0] intensity_i,
    input  logic [CNT_W-1:0]        total_spikes_i,
    input  logic [SLOT_W-1:0]       slot_count_i,
    output logic [NUM_CH-1:0]       spike_o,
    output logic                    slot_valid_o,
    output logic                    frame_done_o,
    output logic                    busy_o
);
    import enc_pkg::*;

    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SUM_W  = VAL_W + IDX_W;
    localparam int DIVD_W = CNT_W + VAL_W + 2;
    localparam int DVS_W  = SUM_W + 1;

    typedef struct packed {
        enc_state_e               st;
        logic [NUM_CH*VAL_W-1:0]  vals;
        logic [CNT_W-1:0]         ns;
        logic [SLOT_W-1:0]        nt;
        logic [IDX_W-1:0]         idx;
        logic [SLOT_W-1:0]        slot;
        logic [NUM_CH*SLOT_W-1:0] remain;
        logic [NUM_CH-1:0]        spk;
        logic                     sv;
        logic                     done;
    } enc_regs_t;

    enc_regs_t r_d, r_q;

    logic [SUM_W-1:0]  sum;
    logic [VAL_W-1:0]  cur_val;
    logic [DIVD_W-1:0] dividend;
    logic [DIVD_W-1:0] quot;
    logic              div_go;
    logic              div_done;
    logic [SLOT_W-1:0] left;
    logic [SLOT_W-1:0] count_sel;
    logic [NUM_CH-1:0] fire;
    logic              run;
    logic [SLOT_W-1:0] nt_latched;

    always_comb begin
        sum = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            sum = sum + SUM_W'(r_q.vals[c*VAL_W +: VAL_W]);
        end
        cur_val  = r_q.vals[r_q.idx*VAL_W +: VAL_W];
        dividend = ((DIVD_W'(r_q.ns) * DIVD_W'(cur_val)) << 1) + DIVD_W'(sum);
    end

    enc_divider #(
        .DIVD_W(DIVD_W),
        .DVS_W (DVS_W)
    ) i_divider (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .go_i      (div_go),
        .dividend_i(dividend),
        .divisor_i ({sum, 1'b0}),
        .quot_o    (quot),
        .done_o    (div_done)
    );

    assign run  = (r_q.st == ENC_RUN);
    assign left = r_q.nt - r_q.slot;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [RND_W-1:0] SEED_C =
            (16'h1D87 ^ RND_W'(c * 16'h2F13)) | 16'h0001;
        logic [RND_W-1:0] rnd;

        enc_lfsr #(.SEED(SEED_C)) i_lfsr (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .adv_i (run),
            .rnd_o (rnd)
        );

        enc_fire_gate #(
            .SLOT_W(SLOT_W),
            .RND_W (RND_W)
        ) i_fire (
            .rnd_i   (rnd),
            .left_i  (left),
            .remain_i(r_q.remain[c*SLOT_W +: SLOT_W]),
            .fire_o  (fire[c])
        );
    end

    always_comb begin
        if (sum == '0)                   count_sel = '0;
        else if (quot > DIVD_W'(r_q.nt)) count_sel = r_q.nt;
        else                             count_sel = quot[SLOT_W-1:0];
    end

    always_comb begin
        r_d      = r_q;
        r_d.spk  = '0;
        r_d.sv   = 1'b0;
        r_d.done = 1'b0;
        div_go   = 1'b0;
        unique case (r_q.st)
            ENC_IDLE: begin
                if (start_i) begin
                    r_d.vals = intensity_i;
                    r_d.ns   = total_spikes_i;
                    r_d.nt   = slot_count_i;
                    r_d.idx  = '0;
                    r_d.st   = ENC_LAUNCH;
                end
            end
            ENC_LAUNCH: begin
                div_go = 1'b1;
                r_d.st = ENC_WAIT;
            end
            ENC_WAIT: begin
                if (div_done) begin
                    r_d.remain[r_q.idx*SLOT_W +: SLOT_W] = count_sel;
                    if (r_q.idx == IDX_W'(NUM_CH - 1)) begin
                        r_d.slot = '0;
                        r_d.st   = ENC_RUN;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ENC_LAUNCH;
                    end
                end
            end
            ENC_RUN: begin
                r_d.sv  = 1'b1;
                r_d.spk = fire;
                for (int c = 0; c < NUM_CH; c++) begin
                    if (fire[c]) begin
                        r_d.remain[c*SLOT_W +: SLOT_W] =
                            r_q.remain[c*SLOT_W +: SLOT_W] - 1'b1;
                    end
                end
                r_d.slot = r_q.slot + 1'b1;
                if (r_q.slot == r_q.nt - 1'b1) begin
                    r_d.done = 1'b1;
                    r_d.st   = ENC_IDLE;
                end
            end
            default: r_d.st = ENC_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ENC_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign nt_latched   = r_q.nt;
    assign spike_o      = r_q.spk;
    assign slot_valid_o = r_q.sv;
    assign frame_done_o = r_q.done;
    assign busy_o       = (r_q.st != ENC_IDLE);
endmodule

// File: rtl/spike_rate_encoder_chk.sv
module spike_rate_encoder_chk #(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [NUM_CH-1:0] spike_o,
    input logic              slot_valid_o,
    input logic              frame_done_o,
    input logic [SLOT_W-1:0] nt_latched
);
    logic [SLOT_W:0] seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           seen_q <= '0;
        else if (frame_done_o) seen_q <= '0;
        else if (slot_valid_o) seen_q <= seen_q + 1'b1;
    end

    a_r7_spike_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|spike_o) |-> slot_valid_o);

    a_r6_done_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |-> slot_valid_o);

    a_r6_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> (!slot_valid_o && !frame_done_o));

    a_r5_slot_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_valid_o |-> (seen_q < {1'b0, nt_latched}));

    a_r5_frame_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |-> (seen_q == {1'b0, nt_latched} - 1'b1));
endmodule

bind spike_rate_encoder spike_rate_encoder_chk #(
    .NUM_CH(NUM_CH),
    .SLOT_W(SLOT_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .spike_o     (spike_o),
    .slot_valid_o(slot_valid_o),
    .frame_done_o(frame_done_o),
    .nt_latched  (nt_latched)
);

// File: tb/test_spike_rate_encoder.sv
`timescale 1ns/1ps
module test_spike_rate_encoder;
    localparam int NUM_CH = 4;
    localparam int VAL_W  = 8;
    localparam int CNT_W  = 12;
    localparam int SLOT_W = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [NUM_CH*VAL_W-1:0] vals = '0;
    logic [CNT_W-1:0]        ns = '0;
    logic [SLOT_W-1:0]       nt = '0;
    logic [NUM_CH-1:0]       spike;
    logic                    slot_valid;
    logic                    frame_done;
    logic                    busy;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    spike_rate_encoder #(
        .NUM_CH(NUM_CH), .VAL_W(VAL_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) i_spike_rate_encoder (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .intensity_i(vals), .total_spikes_i(ns), .slot_count_i(nt),
        .spike_o(spike), .slot_valid_o(slot_valid),
        .frame_done_o(frame_done), .busy_o(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_count(input int v[NUM_CH], input int b,
                                        input int w, input int c);
        int s = 0;
        int q;
        for (int k = 0; k < NUM_CH; k++) s += v[k];
        if (s == 0) return 0;
        q = (2 * b * v[c] + s) / (2 * s);
        return (q > w) ? w : q;
    endfunction

    // Runs one frame; optionally disturbs inputs mid-frame (R8).
    task automatic run_frame(input string tag, input int v[NUM_CH],
                             input int b, input int w, input bit disturb);
        int cnt[NUM_CH];
        int slots = 0;
        int done_ok = 0;
        int guard = 0;
        bit ended = 0;
        for (int k = 0; k < NUM_CH; k++) cnt[k] = 0;
        @(negedge clk);
        for (int k = 0; k < NUM_CH; k++) vals[k*VAL_W +: VAL_W] = VAL_W'(v[k]);
        ns = CNT_W'(b);
        nt = SLOT_W'(w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!ended && guard < 20000) begin
            if (disturb && guard == 40) begin
                vals  = '1;
                ns    = 12'd7;
                nt    = 8'd3;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
            if (slot_valid) begin
                slots++;
                for (int k = 0; k < NUM_CH; k++) cnt[k] += int'(spike[k]);
            end else if (spike != '0) begin
                check({tag, " R7 spike outside slot"}, int'(spike), 0);
            end
            if (frame_done) begin
                done_ok = int'(slot_valid);
                ended = 1;
            end
        end
        start = 1'b0;
        check({tag, " watchdog"}, int'(ended), 1);
        for (int k = 0; k < NUM_CH; k++)
            check($sformatf("%s R2/R3/R4 ch%0d count", tag, k), cnt[k],
                  expect_count(v, b, w, k));
        check({tag, " R5 slot count"}, slots, w);
        check({tag, " R6 done with last slot"}, done_ok, 1);
        @(negedge clk);
        check({tag, " R6 quiet after done"}, int'(slot_valid) + int'(frame_done), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 spike", int'(spike), 0);
        check("R1 slot_valid", int'(slot_valid), 0);
        check("R1 frame_done", int'(frame_done), 0);
        check("R1 busy", int'(busy), 0);
    endtask

    task automatic t_mixed();     // R2
        int v[NUM_CH] = '{40, 80, 120, 200};
        run_frame("mixed", v, 200, 128, 0);
    endtask

    task automatic t_default();   // R2 and R3 at default budget/window
        int v[NUM_CH] = '{1, 2, 3, 250};
        run_frame("default", v, 2000, 128, 0);
    endtask

    task automatic t_half();      // R2 round-half-up: 2.5 -> 3
        int v[NUM_CH] = '{1, 1, 1, 1};
        run_frame("half", v, 10, 32, 0);
    endtask

    task automatic t_clamp();     // R3
        int v[NUM_CH] = '{255, 0, 0, 0};
        run_frame("clamp", v, 2000, 16, 0);
    endtask

    task automatic t_zero();      // R4
        int v[NUM_CH] = '{0, 0, 0, 0};
        run_frame("zero", v, 2000, 20, 0);
    endtask

    task automatic t_ignore();    // R8
        int v[NUM_CH] = '{10, 20, 30, 40};
        run_frame("ignore_R8", v, 60, 50, 1);
    endtask

    task automatic t_back2back(); // R9
        int a[NUM_CH] = '{0, 0, 0, 9};
        int b[NUM_CH] = '{9, 0, 3, 0};
        run_frame("b2b_R9_a", a, 5, 1, 0);
        run_frame("b2b_R9_b", b, 40, 64, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_mixed();
        t_default();
        t_half();
        t_clamp();
        t_zero();
        t_ignore();
        t_back2back();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule